// File: doc/BRIEF.md
# Boundary-Value Stimulus Sequencer

This block generates test vectors for a unit under test whose input is split into six fields: a multi-bit operating mode, a sign bit, an exponent bit string, a round bit, a fraction bit string and a sticky bit. The block does not walk the full binary input space. Each field steps only through a short list of its own values. The mode field takes every one of its codes. Each single bit takes 0 and then 1. Each bit string takes five boundary points: all zeros, one, the middle value (top bit clear, the rest set), the maximum minus one, and all ones.

The fields form a mixed-radix counter. The sticky digit changes fastest and the mode digit changes slowest. With the default widths, the count covers 4 × 2 × 5 × 2 × 5 × 2 = 800 combinations. One vector is offered per cycle on a valid/ready handshake, together with its case index. The same vector stream can feed a rounding stage and a reference model side by side, and a separate comparator then checks their results.

A start pulse begins a run. The block raises done together with the final vector. After that vector is accepted, the block idles and holds its last outputs until the next start pulse.

Top module: `bvseq_top`

## Requirements
- R1: After reset, `vec_valid` = 0, `done` = 0, `case_idx` = 0, and every field output is 0 (the first value of every digit).
- R2: A `start` pulse in any state makes the next cycle present case 0 with `vec_valid` = 1 and `done` = 0. This also applies in the middle of a run, and `start` takes priority over a handshake in the same cycle.
- R3: Digit d (0 to 4) of a bit-string field of width W gives these values: d=0 all zeros; d=1 the value 1; d=2 a 0 in the top bit and ones below it; d=3 ones above and a 0 in bit 0; d=4 all ones. For the 8-bit exponent these are 00, 01, 7F, FE and FF in hex.
- R4: The mode field takes the codes 0 to 2^MODE_W−1 in ascending order. The sign, round and sticky fields take 0 and then 1.
- R5: The digits are ordered from fastest to slowest as sticky, fraction, round, exponent, sign, mode. For case k with default widths: sticky = k mod 2, fraction digit = (k/2) mod 5, round = (k/10) mod 2, exponent digit = (k/20) mod 5, sign = (k/100) mod 2, mode = k/200.
- R6: `case_idx` is the index of the vector being presented. It rises by one on each accepted vector (`vec_valid` and `vec_ready` both high) and runs from 0 to 799.
- R7: While `vec_valid` is high and `vec_ready` is low, the vector and `case_idx` stay unchanged.
- R8: `done` is low for cases 0 to 798 and rises in the cycle that presents case 799. After case 799 is accepted, `vec_valid` drops, `done` stays high, and the outputs hold case 799 until the next `start`.
- R9: When `vec_valid` is low (idle after reset, or finished), `vec_ready` has no effect on `case_idx`, the field outputs or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins (or restarts) a run |
| vec_ready | input | 1 | Consumer accepts the presented vector |
| vec_valid | output | 1 | A vector is presented |
| mode_o | output | MODE_W | Mode field |
| sign_o | output | 1 | Sign field |
| exp_o | output | EXP_W | Exponent bit-string field |
| rnd_o | output | 1 | Round field |
| frac_o | output | FRAC_W | Fraction bit-string field |
| sticky_o | output | 1 | Sticky field |
| case_idx | output | IDX_W | Index of the presented combination |
| done | output | 1 | Final combination presented or finished |

## Verification
The properties assume that `start` and `vec_ready` are driven to known levels in every cycle after reset. They do not assume that `vec_ready` stays high or that `start` is a single-cycle pulse. The stall and index-advance properties exclude cycles in which `start` is high, because a restart overrides a handshake. The stimulus drives every input on the falling clock edge. It applies `vec_ready` patterns from a shift register, applies restarts in the middle of a run, and drives `vec_ready` while the block is idle or finished, so every case the properties cover is exercised with inputs that are always defined.

// File: rtl/bvseq_pkg.sv
package bvseq_pkg;

    // digit positions, fastest first
    localparam int F_STICKY = 0;
    localparam int F_FRAC   = 1;
    localparam int F_RND    = 2;
    localparam int F_EXP    = 3;
    localparam int F_SIGN   = 4;
    localparam int F_MODE   = 5;
    localparam int NUM_F    = 6;

    localparam int STR_POINTS = 5;

    typedef enum logic [1:0] {
        KIND_ENUM = 2'd0,
        KIND_BIT  = 2'd1,
        KIND_STR  = 2'd2
    } field_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_FIN  = 2'd2
    } seq_state_e;

    function automatic int radix_of(input int pos, input int mode_w);
        case (pos)
            F_STICKY, F_RND, F_SIGN: return 2;
            F_FRAC, F_EXP:           return STR_POINTS;
            default:                 return 1 << mode_w;
        endcase
    endfunction

    function automatic int digit_width(input int mode_w);
        int mr;
        mr = ((1 << mode_w) > STR_POINTS) ? (1 << mode_w) : STR_POINTS;
        return $clog2(mr);
    endfunction

    function automatic int total_cases(input int mode_w);
        int t;
        t = 1;
        for (int i = 0; i < NUM_F; i++) t = t * radix_of(i, mode_w);
        return t;
    endfunction

endpackage

// File: rtl/bvseq_digit.sv
module bvseq_digit #(
    parameter int RADIX = 5,
    parameter int DW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [DW-1:0] val,
    output logic          at_max
);
    localparam logic [DW-1:0] TOP = DW'(RADIX - 1);

    assign at_max = (val == TOP);

    always_ff @(posedge clk) begin
        if (rst || clr)
            val <= '0;
        else if (inc)
            val <= at_max ? '0 : val + 1'b1;
    end
endmodule

// File: rtl/bvseq_decode.sv
module bvseq_decode
    import bvseq_pkg::*;
#(
    parameter field_kind_e KIND = KIND_STR,
    parameter int          W    = 8,
    parameter int          DW   = 3
) (
    input  logic [DW-1:0] dig,
    output logic [W-1:0]  value
);
    generate
        if (KIND == KIND_STR) begin : g_str
            always_comb begin
                case (dig)
                    DW'(0):  value = '0;
                    DW'(1):  value = W'(1);
                    DW'(2):  value = {1'b0, {(W-1){1'b1}}};
                    DW'(3):  value = {{(W-1){1'b1}}, 1'b0};
                    default: value = '1;
                endcase
            end
        end else if (KIND == KIND_BIT) begin : g_bit
            assign value = W'(dig != '0);
        end else begin : g_enum
            assign value = W'(dig);
        end
    endgenerate
endmodule

// File: rtl/bvseq_top.sv
module bvseq_top
    import bvseq_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int IDX_W  = $clog2(total_cases(MODE_W))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              vec_ready,
    output logic              vec_valid,
    output logic [MODE_W-1:0] mode_o,
    output logic              sign_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              rnd_o,
    output logic [FRAC_W-1:0] frac_o,
    output logic              sticky_o,
    output logic [IDX_W-1:0]  case_idx,
    output logic              done
);
    localparam int DW    = digit_width(MODE_W);
    localparam int TOTAL = total_cases(MODE_W);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

    seq_state_e state;
    logic       adv, last;
    logic [DW-1:0] dig   [NUM_F];
    logic [NUM_F:0] carry;
    logic [NUM_F-1:0] wrap;

    assign last      = (case_idx == LAST);
    assign vec_valid = (state == SQ_RUN);
    assign adv       = vec_valid && vec_ready && !start;
    assign done      = (state == SQ_FIN) || (vec_valid && last);

    // sequence control and index
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            case_idx <= '0;
        end else if (start) begin
            state    <= SQ_RUN;
            case_idx <= '0;
        end else if (adv) begin
            if (last)
                state <= SQ_FIN;
            else
                case_idx <= case_idx + 1'b1;
        end
    end

    // mixed-radix digit chain
    assign carry[0] = adv && !last;
    generate
        for (genvar i = 0; i < NUM_F; i++) begin : g_dig
            bvseq_digit #(
                .RADIX(radix_of(i, MODE_W)),
                .DW   (DW)
            ) digit_i (
                .clk   (clk),
                .rst   (rst),
                .clr   (start),
                .inc   (carry[i]),
                .val   (dig[i]),
                .at_max(wrap[i])
            );
            assign carry[i+1] = carry[i] && wrap[i];
        end
    endgenerate

    // digit to field value
    bvseq_decode #(.KIND(KIND_BIT),  .W(1),      .DW(DW)) dec_sticky (.dig(dig[F_STICKY]), .value(sticky_o));
    bvseq_decode #(.KIND(KIND_STR),  .W(FRAC_W), .DW(DW)) dec_frac   (.dig(dig[F_FRAC]),   .value(frac_o));
    bvseq_decode #(.KIND(KIND_BIT),  .W(1),      .DW(DW)) dec_rnd    (.dig(dig[F_RND]),    .value(rnd_o));
    bvseq_decode #(.KIND(KIND_STR),  .W(EXP_W),  .DW(DW)) dec_exp    (.dig(dig[F_EXP]),    .value(exp_o));
    bvseq_decode #(.KIND(KIND_BIT),  .W(1),      .DW(DW)) dec_sign   (.dig(dig[F_SIGN]),   .value(sign_o));
    bvseq_decode #(.KIND(KIND_ENUM), .W(MODE_W), .DW(DW)) dec_mode   (.dig(dig[F_MODE]),   .value(mode_o));
endmodule

// File: rtl/bvseq_chk.sv
module bvseq_chk
    import bvseq_pkg::*;
#(
    parameter int MODE_W = 2,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int IDX_W  = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              vec_ready,
    input logic              vec_valid,
    input logic [MODE_W-1:0] mode_o,
    input logic              sign_o,
    input logic [EXP_W-1:0]  exp_o,
    input logic              rnd_o,
    input logic [FRAC_W-1:0] frac_o,
    input logic              sticky_o,
    input logic [IDX_W-1:0]  case_idx,
    input logic              done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(total_cases(MODE_W) - 1);
    localparam logic [EXP_W-1:0] E_MID = {1'b0, {(EXP_W-1){1'b1}}};
    localparam logic [EXP_W-1:0] E_HI  = {{(EXP_W-1){1'b1}}, 1'b0};

    // R2
    start_restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> vec_valid && case_idx == '0 && !done);

    // R3
    exp_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        exp_o == '0 || exp_o == EXP_W'(1) || exp_o == E_MID || exp_o == E_HI || exp_o == '1);

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid && vec_ready && !start && case_idx != LAST |=> case_idx == $past(case_idx) + 1'b1);

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        case_idx <= LAST);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid && !vec_ready && !start |=> vec_valid && $stable(case_idx) && $stable(mode_o)
        && $stable(sign_o) && $stable(exp_o) && $stable(rnd_o) && $stable(frac_o) && $stable(sticky_o));

    // R8
    done_with_last_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (done == (case_idx == LAST)));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        done && !vec_valid && !start |=> done && !vec_valid && $stable(case_idx));

    // R9
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !vec_valid && !start |=> !vec_valid && $stable(case_idx) && $stable(exp_o) && $stable(done));
endmodule

bind bvseq_top bvseq_chk #(
    .MODE_W(MODE_W), .EXP_W(EXP_W), .FRAC_W(FRAC_W), .IDX_W(IDX_W)
) chk_i (.*);

// File: tb/bvseq_top_tb.sv
module bvseq_top_tb_top;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst, start, vec_ready;
    logic        vec_valid, sign_o, rnd_o, sticky_o, done;
    logic [1:0]  mode_o;
    logic [7:0]  exp_o;
    logic [22:0] frac_o;
    logic [9:0]  case_idx;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(PERIOD/2) clk = ~clk;

    bvseq_top dut_i (
        .clk(clk), .rst(rst), .start(start), .vec_ready(vec_ready),
        .vec_valid(vec_valid), .mode_o(mode_o), .sign_o(sign_o), .exp_o(exp_o),
        .rnd_o(rnd_o), .frac_o(frac_o), .sticky_o(sticky_o),
        .case_idx(case_idx), .done(done)
    );

    // R3 boundary points
    function automatic logic [7:0] e_pt(input int d);
        case (d)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h7F; 3: return 8'hFE;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [22:0] f_pt(input int d);
        case (d)
            0: return 23'h000000; 1: return 23'h000001; 2: return 23'h3FFFFF;
            3: return 23'h7FFFFE; default: return 23'h7FFFFF;
        endcase
    endfunction

    // R4 R5 expected packed vector for case k
    function automatic logic [35:0] exp_vec(input int k);
        return {2'(k / 200), 1'((k / 100) % 2), e_pt((k / 20) % 5),
                1'((k / 10) % 2), f_pt((k / 2) % 5), 1'(k % 2)};
    endfunction

    function automatic logic [35:0] act_vec();
        return {mode_o, sign_o, exp_o, rnd_o, frac_o, sticky_o};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // checks presented vector for case k with given valid/done
    task automatic chk_case(input string req, input int k, input logic v, input logic d);
        chk(req, {28'd0, act_vec()}, {28'd0, exp_vec(k)});
        chk(req, 64'(case_idx), 64'(k));
        chk(req, 64'({vec_valid, done}), 64'({v, d}));
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; vec_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_case("R1 reset state", 0, 1'b0, 1'b0);
        // R9 ready while idle
        vec_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk_case("R9 ready ignored when idle", 0, 1'b0, 1'b0);
    endtask

    task automatic t_full_run();
        vec_ready = 1'b1;
        pulse_start();
        for (int k = 0; k < 800; k++) begin
            chk_case("R5 R6 R8 full run", k, 1'b1, k == 799);
            @(negedge clk);
        end
        chk_case("R8 finished hold", 799, 1'b0, 1'b1);
        // R9 ready toggles while finished
        for (int i = 0; i < 4; i++) begin
            vec_ready = i[0];
            @(negedge clk);
        end
        chk_case("R9 ready ignored when finished", 799, 1'b0, 1'b1);
    endtask

    task automatic t_backpressure();
        int k;
        int guard;
        k = 0; guard = 0;
        vec_ready = 1'b0;
        pulse_start();
        while (k < 800 && guard < 4000) begin
            logic r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = lfsr[0] | lfsr[3];
            chk_case("R7 stalled stream", k, 1'b1, k == 799);
            vec_ready = r;
            @(negedge clk);
            if (r) k++;
            guard++;
        end
        chk("R7 stream completed", 64'(k), 64'd800);
        chk_case("R8 end after stalls", 799, 1'b0, 1'b1);
    endtask

    task automatic t_restart();
        vec_ready = 1'b1;
        pulse_start();
        repeat (37) @(negedge clk);
        chk_case("R6 mid run", 37, 1'b1, 1'b0);
        pulse_start();
        chk_case("R2 restart mid run", 0, 1'b1, 1'b0);
        repeat (22) @(negedge clk);
        chk_case("R3 R5 after restart", 22, 1'b1, 1'b0);
        // R3 middle exponent and fraction points
        vec_ready = 1'b0;
        pulse_start();
        chk_case("R2 restart with stall", 0, 1'b1, 1'b0);
        vec_ready = 1'b1;
        repeat (45) @(negedge clk);
        chk_case("R3 exponent middle point", 45, 1'b1, 1'b0);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; vec_ready = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_run();
        t_backpressure();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule